// File: doc/BRIEF.md
# Offset-Limited Request Strobe Pacer

This block paces request strobes on the wide secondary data lanes of a target device. Each rising edge of a slow pacing input gives one chance to issue a strobe. An up/down counter tracks how many requests are still outstanding. No strobe is issued once that count reaches the programmed synchronous offset. A synchronous clear sets the count back to zero at the start of every data phase.

The block has two modes, chosen by `mode_send`.

- **Receive mode** (`mode_send` = 0): a request is retired when the local memory logic finishes a word with `dma_ack`.
- **Send mode** (`mode_send` = 1): a request is retired by `ini_ack`, the acknowledge that comes back from the initiator. A request is issued only while the lane FIFO holds a word. A FIFO read pulse follows each strobe after a fixed skew of `SKEW` clock cycles and moves the next word onto the lanes.

No data passes through this block, so every pin is a plain level or a one-cycle pulse and none has back-pressure.

Top module: `strobe_pacer`

## Requirements
- R1: After reset, `outstanding` is 0 and `req_strobe` and `fifo_pop` are low.
- R2: A rising edge of `pace_in`, seen between two consecutive clock samples, issues at most one request. An issued request shows `req_strobe` high for exactly one cycle, in the cycle after the edge that sampled `pace_in` high. `outstanding` rises by one at that same edge.
- R3: No request is issued while `outstanding >= offset_lim`. `at_limit` equals (`outstanding >= offset_lim`), using the present limit.
- R4: In receive mode (`mode_send` = 0), a sampled `dma_ack` lowers `outstanding` by one and `ini_ack` has no effect.
- R5: In send mode (`mode_send` = 1), a sampled `ini_ack` lowers `outstanding` by one and `dma_ack` has no effect.
- R6: A request issued in the same cycle as a sampled retire acknowledge leaves `outstanding` unchanged.
- R7: A retire acknowledge while `outstanding` is 0 and no request is issued is ignored, so the count stays 0.
- R8: In send mode, no request is issued while `fifo_not_empty` is low.
- R9: In send mode, `fifo_pop` pulses for one cycle exactly `SKEW` cycles after each `req_strobe` pulse (default `SKEW` = 2). In receive mode, `fifo_pop` stays low.
- R10: In send mode, no request is issued while a strobe's FIFO read is still pending, up to and including its `fifo_pop` cycle.
- R11: A sampled `clr` sets `outstanding` to 0, issues no request and cancels pending FIFO reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear at the start of a data phase |
| mode_send | input | 1 | 0 = receive mode, 1 = send mode |
| offset_lim | input | CW | Synchronous offset limit (CW = clog2(MAX_OFFSET+1)) |
| pace_in | input | 1 | Pacing clock, level; its rising edges pace the strobes |
| dma_ack | input | 1 | Local DMA acknowledge (retires a request in receive mode) |
| ini_ack | input | 1 | Initiator acknowledge (retires a request in send mode) |
| fifo_not_empty | input | 1 | Lane FIFO holds a word |
| req_strobe | output | 1 | One-cycle request strobe |
| fifo_pop | output | 1 | One-cycle FIFO read pulse |
| at_limit | output | 1 | Outstanding count has reached the limit |
| outstanding | output | CW | Current outstanding request count |

## Verification
`req_strobe` and `outstanding` change one clock edge after the inputs that cause them are sampled. `at_limit` is combinational from the count and the present limit. `fifo_pop` appears `SKEW` cycles after its strobe, which is `SKEW`+1 edges after the pacing edge was sampled.

The bench drives inputs on the falling edge. On each falling edge it first compares every output with a reference model, and only then does it drive new inputs. The model is advanced once per clock edge, so every expected value lines up with the cycle in which the design's registered output is due. Directed runs cover these corners:

- a limit of zero;
- a retire that arrives while the count is zero;
- a request and a retire in the same cycle;
- an empty FIFO;
- a FIFO read still pending;
- a clear that arrives mid-skew.

Seeded random traffic covers both modes in between.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic {
    PM_RECV = 1'b0,
    PM_SEND = 1'b1
  } pace_mode_e;
endpackage

// File: rtl/pacer_counter.sv
module pacer_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          up,
  input  logic          retire,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (up && retire) begin
      cnt <= cnt;
    end else if (up) begin
      cnt <= cnt + ONE;
    end else if (retire && (cnt != '0)) begin
      cnt <= cnt - ONE;
    end
  end

  assign full = (cnt >= limit);

  // R7: retire at zero count is ignored
  assert_zero_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && retire && !up && !clr) |=> (cnt == '0));

  // R6: simultaneous request and retire hold the count
  assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && retire && !clr) |=> $stable(cnt));
endmodule

// File: rtl/pacer_skew.sv
module pacer_skew #(
  parameter int SKEW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic launch,
  output logic pop,
  output logic busy
);
  localparam int NST = SKEW + 1;

  logic [NST-1:0] stage;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic nxt;
    if (k == 0) begin : g_head
      assign nxt = launch;
    end else begin : g_tail
      assign nxt = stage[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stage[k] <= 1'b0;
      else if (clr) stage[k] <= 1'b0;
      else          stage[k] <= nxt;
    end
  end

  assign pop  = stage[NST-1];
  assign busy = |stage;

  // R9: the pending window only closes after a pop or a clear
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pop || clr));
endmodule

// File: rtl/pacer_gate.sv
module pacer_gate
  import pacer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  pace_mode_e mode,
  input  logic       pace_in,
  input  logic       below,
  input  logic       fifo_ne,
  input  logic       busy,
  output logic       issue,
  output logic       req_q
);
  logic pace_prev;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pace_prev <= 1'b0;
    else        pace_prev <= pace_in;
  end

  assign rise = pace_in && !pace_prev;

  always_comb begin
    issue = rise && !clr && below;
    if (mode == PM_SEND) issue = issue && fifo_ne && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= issue;
  end

  // R2: strobe lasts one cycle
  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
endmodule

// File: rtl/strobe_pacer.sv
module strobe_pacer
  import pacer_pkg::*;
#(
  parameter int MAX_OFFSET = 15,
  parameter int SKEW       = 2,
  localparam int CW        = $clog2(MAX_OFFSET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mode_send,
  input  logic [CW-1:0] offset_lim,
  input  logic          pace_in,
  input  logic          dma_ack,
  input  logic          ini_ack,
  input  logic          fifo_not_empty,
  output logic          req_strobe,
  output logic          fifo_pop,
  output logic          at_limit,
  output logic [CW-1:0] outstanding
);
  pace_mode_e mode;
  logic       issue;
  logic       retire;
  logic       busy;
  logic       full;

  assign mode   = pace_mode_e'(mode_send);
  assign retire = (mode == PM_SEND) ? ini_ack : dma_ack;

  pacer_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mode    (mode),
    .pace_in (pace_in),
    .below   (!full),
    .fifo_ne (fifo_not_empty),
    .busy    (busy),
    .issue   (issue),
    .req_q   (req_strobe)
  );

  pacer_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .up     (issue),
    .retire (retire),
    .limit  (offset_lim),
    .cnt    (outstanding),
    .full   (full)
  );

  pacer_skew #(.SKEW(SKEW)) u_skew (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .launch (issue && (mode == PM_SEND)),
    .pop    (fifo_pop),
    .busy   (busy)
  );

  assign at_limit = full;

  // R3: a strobe only follows a count below the limit
  assert_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(outstanding < offset_lim));

  // R8: send-mode strobe only with FIFO data present
  assert_fifo_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(!mode_send || fifo_not_empty));

  // R10: send-mode strobe never overlaps a pending read
  assert_one_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(!mode_send || !busy));

  // R11: clear empties the count and suppresses activity
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (outstanding == '0 && !req_strobe && !fifo_pop));
endmodule

// File: tb/sim_strobe_pacer.sv
module sim_strobe_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXO       = 15;
  localparam int SKEW       = 2;
  localparam int CW         = $clog2(MAXO + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr, mode_send, pace_in, dma_ack, ini_ack, fifo_not_empty;
  logic [CW-1:0] offset_lim;
  logic          req_strobe, fifo_pop, at_limit;
  logic [CW-1:0] outstanding;

  strobe_pacer #(.MAX_OFFSET(MAXO), .SKEW(SKEW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_send(mode_send),
    .offset_lim(offset_lim), .pace_in(pace_in), .dma_ack(dma_ack),
    .ini_ack(ini_ack), .fifo_not_empty(fifo_not_empty),
    .req_strobe(req_strobe), .fifo_pop(fifo_pop), .at_limit(at_limit),
    .outstanding(outstanding)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  string       ctag   = "R1";
  int          m_cnt  = 0;
  bit          m_req  = 0;
  bit          m_prev = 0;
  bit [SKEW:0] m_d    = '0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", ctag, what, act, exp);
    end
  endtask

  function automatic int next_cnt(input int c, input bit clr_i, input bit up, input bit ret);
    if (clr_i)          return 0;
    if (up && ret)      return c;
    if (up)             return c + 1;
    if (ret && (c > 0)) return c - 1;
    return c;
  endfunction

  // one cycle: compare outputs, then drive inputs and advance the model
  task automatic cyc(input bit c, input bit m, input int l, input bit p,
                     input bit da, input bit ia, input bit f);
    bit busy, issue, ret;
    @(negedge clk);
    chk("outstanding", int'(outstanding), m_cnt);
    chk("req_strobe", int'(req_strobe), int'(m_req));
    chk("fifo_pop", int'(fifo_pop), int'(m_d[SKEW]));
    chk("at_limit", int'(at_limit), (m_cnt >= int'(offset_lim)) ? 1 : 0);
    clr = c; mode_send = m; offset_lim = CW'(l); pace_in = p;
    dma_ack = da; ini_ack = ia; fifo_not_empty = f;
    busy  = |m_d;
    issue = p && !m_prev && !c && (m_cnt < l) && (!m || (f && !busy));
    ret   = m ? ia : da;
    m_cnt = next_cnt(m_cnt, c, issue, ret);
    m_req = issue;
    m_d   = c ? '0 : {m_d[SKEW-1:0], issue && m};
    m_prev = p;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr = 0; mode_send = 0; offset_lim = '0; pace_in = 0;
    dma_ack = 0; ini_ack = 0; fifo_not_empty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctag = "R1";
    cyc(0, 0, 4, 0, 0, 0, 0);
    cyc(0, 0, 4, 0, 0, 0, 0);
    // R7: acknowledge at zero count is ignored
    ctag = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 4, 0, 1, 0, 0);
    // R3: limit of zero blocks, then limit 2 saturates
    ctag = "R3";
    for (int i = 0; i < 3; i++) begin cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0); end
    for (int i = 0; i < 4; i++) begin cyc(0, 0, 2, 1, 0, 0, 0); cyc(0, 0, 2, 0, 0, 0, 0); end
    // R4: ini_ack ignored in receive mode, dma_ack retires
    ctag = "R4";
    cyc(0, 0, 2, 0, 0, 1, 0); cyc(0, 0, 2, 0, 0, 0, 0);
    cyc(0, 0, 2, 0, 1, 0, 0); cyc(0, 0, 2, 0, 0, 0, 0);
    // R6: request and retire together
    ctag = "R6";
    cyc(0, 0, 4, 1, 1, 0, 0); cyc(0, 0, 4, 0, 0, 0, 0); cyc(0, 0, 4, 0, 0, 0, 0);
    // R2: pace held high gives one strobe only
    ctag = "R2";
    for (int i = 0; i < 5; i++) cyc(0, 0, 4, 1, 0, 0, 0);
    cyc(0, 0, 4, 0, 0, 0, 0);
    // R11: clear, then enter send mode
    ctag = "R11";
    cyc(1, 1, 8, 0, 0, 0, 0); cyc(0, 1, 8, 0, 0, 0, 0);
    // R8: empty FIFO blocks requests
    ctag = "R8";
    for (int i = 0; i < 3; i++) begin cyc(0, 1, 8, 1, 0, 0, 0); cyc(0, 1, 8, 0, 0, 0, 0); end
    // R10 / R9: fast pacing with data present, pops after skew
    ctag = "R10";
    for (int i = 0; i < 6; i++) begin cyc(0, 1, 8, 1, 0, 0, 1); cyc(0, 1, 8, 0, 0, 0, 1); end
    ctag = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 1, 8, 0, 0, 0, 1);
    // R5: dma_ack ignored in send mode, ini_ack retires
    ctag = "R5";
    cyc(0, 1, 8, 0, 1, 0, 1); cyc(0, 1, 8, 0, 0, 1, 1); cyc(0, 1, 8, 0, 0, 0, 1);
    // R11: clear while a pop is pending cancels it
    ctag = "R11";
    cyc(0, 1, 8, 1, 0, 0, 1); cyc(0, 1, 8, 0, 0, 0, 1);
    cyc(1, 1, 8, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 1, 8, 0, 0, 0, 1);
    // random phases in both modes
    for (int ph = 0; ph < 40; ph++) begin
      bit m = ph[0];
      int l = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom % (MAXO + 1));
      bit p = 0;
      ctag = m ? "R5" : "R4";
      cyc(1, m, l, 0, 0, 0, 0);
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 2 == 0) p = !p;
        if ($urandom % 97 == 0) l = int'($urandom % (MAXO + 1));
        cyc(($urandom % 300) == 0, m, l, p, ($urandom % 4) == 0,
            ($urandom % 4) == 0, ($urandom % 4) != 0);
      end
    end
    cyc(0, 0, 4, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule